// File: doc/BRIEF.md
# Mezzanine carrier interrupt controller

This block holds the register and interrupt logic of a carrier that hosts four plug-in modules, each driving two interrupt request lines. Every slot has an 8-bit control register that enables each of its two lines and picks edge or level mode for each. A 16-bit status register collects the per-line interrupt flags and four per-slot timeout flags. All eight sources are merged onto one host interrupt line.

Level-mode sources drive the host line directly: it is high while any level-mode flag is set. An edge-mode source that becomes set makes the host line flip for exactly one cycle and then return to the level given by the level-mode sources. Flags are cleared by the source's own falling request, by writing one to the status bit, or by an acknowledging read of the module's interrupt space (level-mode only). The host reaches the registers through a plain 16-bit write strobe and a combinational read port.

Top module: `mzc_irq_ctrl`

## Requirements
- R1: After reset every control register, every status bit and the host line read 0.
- R2: Offsets 0x02, 0x04, 0x06 and 0x08 hold the control registers of slots 0..3 (slot = offset/2 - 1) and read back the low 8 written bits; offsets 0x00, 0x0A and any unmapped offset read 0, and writes to them change no register.
- R3: Control bit 6+n enables line n of the slot and bit 4+n puts that line in edge mode; the flag of slot s line n is status bit 2*s+n.
- R4: While a line's enable bit is clear, changes on its request input alter neither its status bit nor the host line.
- R5: With the line enabled, a rising request sets its status bit and a falling request clears it, one clock edge after the input change is sampled.
- R6: The host line is high whenever at least one status flag of a level-mode source is set and no edge pulse is active, and low when none is.
- R7: When an edge-mode source's flag goes from 0 to 1, the host line is inverted for exactly one cycle, in the same cycle the flag first reads 1; edge-mode flags do not hold the host line.
- R8: Writing 1 to status bit 2*s+n at offset 0x0C clears that enabled flag only when slot s is populated; an unpopulated slot's flag stays set.
- R9: An acknowledge for slot s at interrupt-space offset 0 (line 0) or 2 (line 1) clears the flag only if the line is enabled and in level mode; an edge-mode flag stays set.
- R10: A pulse on the timeout event input of slot s sets status bit 12+s; writing 1 to that bit clears it.
- R11: A status write with any of bits 8..11 set changes no state and drives the unexpected-write output high for one cycle.
- R12: If a rising request and a clear (write-one or acknowledge) hit the same flag on the same edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| slot_present_i | input | 4 | Slot populated flags |
| mod_irq_i | input | 8 | Module request lines, index 2*slot+line |
| ack_i | input | 1 | Interrupt-space read strobe |
| ack_slot_i | input | 2 | Slot of the acknowledging read |
| ack_off_i | input | 6 | Interrupt-space offset of the read |
| tmo_set_i | input | 4 | Timeout event per slot |
| host_irq_o | output | 1 | Merged host interrupt |
| bad_wr_o | output | 1 | Unexpected status write seen |

## Verification
The collision that matters is a module request rising on the same clock edge as a software clear of the same flag, by write-one-to-clear or by acknowledge. The bench raises the request line in the same half-cycle as it presents the clearing write or acknowledge, then reads the status word after that edge and expects the flag still set. It also lets an edge-mode pulse land while a level-mode source holds the host line high, and judges that the line dips low for exactly one cycle.

// File: rtl/mzc_pkg.sv
package mzc_pkg;
  localparam int unsigned NSLOT_DEF    = 4;
  localparam int unsigned NLINE_DEF    = 2;
  localparam int unsigned CTRL_W       = 8;
  localparam int unsigned CTRL_EDGE_LSB = 4;
  localparam int unsigned CTRL_EN_LSB   = 6;
  localparam int unsigned STAT_ERR_LSB  = 8;
  localparam int unsigned STAT_ERR_W    = 4;
  localparam int unsigned STAT_TMO_LSB  = 12;
  localparam logic [7:0]  ADDR_REV   = 8'h00;
  localparam logic [7:0]  ADDR_CTRL0 = 8'h02;
  localparam logic [7:0]  ADDR_RST   = 8'h0A;
  localparam logic [7:0]  ADDR_STAT  = 8'h0C;
endpackage

// File: rtl/mzc_src.sv
module mzc_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic en_i,
  input  logic edge_i,
  input  logic w1c_i,
  input  logic ack_i,
  output logic stat_o,
  output logic pulse_o
);
  logic prev_q, stat_q, pulse_q;
  logic rise, fall, clr, set;

  assign rise = req_i & ~prev_q;
  assign fall = ~req_i & prev_q;
  assign set  = en_i & rise;
  // ack only clears level-mode sources
  assign clr  = en_i & (fall | w1c_i | (ack_i & ~edge_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      stat_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= req_i;
      pulse_q <= set & edge_i & ~stat_q;
      if (set)      stat_q <= 1'b1;
      else if (clr) stat_q <= 1'b0;
    end
  end

  assign stat_o  = stat_q;
  assign pulse_o = pulse_q;

  a_r4_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(stat_o));
  a_r5_fall_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && prev_q && !req_i) |=> !stat_o);
  a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && req_i && !prev_q) |=> stat_o);
  a_r7_pulse_on_new_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (stat_o && !$past(stat_o)));
endmodule

// File: rtl/mzc_regfile.sv
module mzc_regfile
  import mzc_pkg::*;
#(
  parameter int unsigned N_SLOTS = NSLOT_DEF,
  parameter int unsigned N_LINES = NLINE_DEF,
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 16,
  localparam int unsigned N_SRC  = N_SLOTS * N_LINES
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [DW-1:0]                  wdata_i,
  input  logic [N_SRC-1:0]               stat_i,
  input  logic [N_SLOTS-1:0]             tmo_set_i,
  input  logic [N_SLOTS-1:0]             present_i,
  output logic [N_SLOTS-1:0][CTRL_W-1:0] ctrl_o,
  output logic [N_SRC-1:0]               w1c_o,
  output logic [DW-1:0]                  rdata_o,
  output logic                           bad_wr_o
);
  logic [N_SLOTS-1:0] tmo_q;
  logic               bad_q;
  logic               stat_wr, stat_bad, stat_ok;

  assign stat_wr  = we_i && (addr_i == AW'(ADDR_STAT));
  assign stat_bad = stat_wr && (|wdata_i[STAT_ERR_LSB +: STAT_ERR_W]);
  assign stat_ok  = stat_wr && !stat_bad;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    localparam logic [AW-1:0] CADDR = AW'(ADDR_CTRL0) + AW'(2 * s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        ctrl_o[s] <= '0;
      else if (we_i && addr_i == CADDR)   ctrl_o[s] <= wdata_i[CTRL_W-1:0];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        tmo_q[s] <= 1'b0;
      else if (tmo_set_i[s]) tmo_q[s] <= 1'b1;
      else if (stat_ok && wdata_i[STAT_TMO_LSB + s]) tmo_q[s] <= 1'b0;
    end
    for (genvar n = 0; n < N_LINES; n++) begin : g_line
      assign w1c_o[s*N_LINES+n] = stat_ok & wdata_i[s*N_LINES+n] & present_i[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bad_q <= 1'b0;
    else         bad_q <= stat_bad;
  end
  assign bad_wr_o = bad_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_STAT)) begin
      rdata_o[N_SRC-1:0]              = stat_i;
      rdata_o[STAT_TMO_LSB +: N_SLOTS] = tmo_q;
    end
    for (int s = 0; s < N_SLOTS; s++)
      if (addr_i == AW'(ADDR_CTRL0) + AW'(2 * s)) rdata_o[CTRL_W-1:0] = ctrl_o[s];
  end

  a_r10_tmo_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_set_i != '0) |=> ((tmo_q & $past(tmo_set_i)) == $past(tmo_set_i)));
  a_r11_bad_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_bad && tmo_set_i == '0) |=> ($stable(tmo_q) && bad_wr_o));
  a_r11_bad_no_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_bad |-> (w1c_o == '0));
endmodule

// File: rtl/mzc_irq_ctrl.sv
module mzc_irq_ctrl
  import mzc_pkg::*;
#(
  parameter int unsigned N_SLOTS = NSLOT_DEF,
  parameter int unsigned N_LINES = NLINE_DEF,
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 16,
  parameter int unsigned OFF_W   = 6,
  localparam int unsigned N_SRC  = N_SLOTS * N_LINES,
  localparam int unsigned SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic [N_SLOTS-1:0] slot_present_i,
  input  logic [N_SRC-1:0]   mod_irq_i,
  input  logic               ack_i,
  input  logic [SLOT_W-1:0]  ack_slot_i,
  input  logic [OFF_W-1:0]   ack_off_i,
  input  logic [N_SLOTS-1:0] tmo_set_i,
  output logic               host_irq_o,
  output logic               bad_wr_o
);
  logic [N_SLOTS-1:0][CTRL_W-1:0] ctrl;
  logic [N_SRC-1:0] stat, pulse, w1c, ack_hit, lvl_src;

  mzc_regfile #(.N_SLOTS(N_SLOTS), .N_LINES(N_LINES), .AW(AW), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .stat_i    (stat),
    .tmo_set_i (tmo_set_i),
    .present_i (slot_present_i),
    .ctrl_o    (ctrl),
    .w1c_o     (w1c),
    .rdata_o   (reg_rdata_o),
    .bad_wr_o  (bad_wr_o)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    for (genvar n = 0; n < N_LINES; n++) begin : g_line
      localparam int unsigned K = s * N_LINES + n;
      assign ack_hit[K] = ack_i && slot_present_i[s] &&
                          (ack_slot_i == SLOT_W'(s)) && (ack_off_i == OFF_W'(2 * n));
      assign lvl_src[K] = stat[K] & ~ctrl[s][CTRL_EDGE_LSB + n];
      mzc_src u_src (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (mod_irq_i[K]),
        .en_i    (ctrl[s][CTRL_EN_LSB + n]),
        .edge_i  (ctrl[s][CTRL_EDGE_LSB + n]),
        .w1c_i   (w1c[K]),
        .ack_i   (ack_hit[K]),
        .stat_o  (stat[K]),
        .pulse_o (pulse[K])
      );
    end
  end

  // level flag from level-mode sources only; edge pulse flips it for one cycle
  assign host_irq_o = (|lvl_src) ^ (|pulse);

  a_r6_host_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat == '0) |-> !host_irq_o);
  a_r7_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulse) |=> ((pulse & $past(pulse)) == '0));
endmodule

// File: tb/mzc_irq_ctrl_test.sv
`timescale 1ns/1ps
module mzc_irq_ctrl_test;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        we = 0;
  logic [7:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [3:0]  present = 4'b0111;
  logic [7:0]  mod = 0;
  logic        ack = 0;
  logic [1:0]  ack_slot = 0;
  logic [5:0]  ack_off = 0;
  logic [3:0]  tmo = 0;
  logic        host, bad;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mzc_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .slot_present_i(present),
    .mod_irq_i(mod), .ack_i(ack), .ack_slot_i(ack_slot), .ack_off_i(ack_off),
    .tmo_set_i(tmo), .host_irq_o(host), .bad_wr_o(bad)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    we = 1; addr = a; wdata = d;
    step();
    we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(8'(2 + 2*s), v); chk("R1 ctrl", v, 16'h0);
    end
    rd(8'h0C, v); chk("R1 status", v, 16'h0);
    chk("R1 host", {15'b0, host}, 16'h0);
  endtask

  task automatic t_map();
    logic [15:0] v;
    wr(8'h02, 16'hFF0F); wr(8'h04, 16'h00A5); wr(8'h06, 16'h003C); wr(8'h08, 16'h1211);
    rd(8'h02, v); chk("R2 ctrl0", v, 16'h000F);
    rd(8'h04, v); chk("R2 ctrl1", v, 16'h00A5);
    rd(8'h06, v); chk("R2 ctrl2", v, 16'h003C);
    rd(8'h08, v); chk("R2 ctrl3", v, 16'h0011);
    wr(8'h00, 16'hBEEF); wr(8'h0A, 16'h5555); wr(8'h0E, 16'h7777);
    rd(8'h00, v); chk("R2 rev", v, 16'h0);
    rd(8'h0A, v); chk("R2 rst", v, 16'h0);
    rd(8'h0E, v); chk("R2 unmapped", v, 16'h0);
    rd(8'h04, v); chk("R2 ctrl1 kept", v, 16'h00A5);
    for (int s = 0; s < 4; s++) wr(8'(2 + 2*s), 16'h0);
  endtask

  task automatic t_disabled();
    logic [15:0] v;
    mod[0] = 1; step(); step();
    rd(8'h0C, v); chk("R4 status", v, 16'h0);
    chk("R4 host", {15'b0, host}, 16'h0);
    mod[0] = 0; step();
  endtask

  task automatic t_level();
    logic [15:0] v;
    wr(8'h02, 16'h0040);
    mod[0] = 1; step();
    rd(8'h0C, v); chk("R5 R3 set bit0", v, 16'h0001);
    chk("R6 host high", {15'b0, host}, 16'h1);
    step(); chk("R6 host holds", {15'b0, host}, 16'h1);
    mod[0] = 0; step();
    rd(8'h0C, v); chk("R5 clear", v, 16'h0);
    chk("R6 host low", {15'b0, host}, 16'h0);
  endtask

  task automatic t_edge();
    logic [15:0] v;
    wr(8'h04, 16'h00A0);
    mod[3] = 1; step();
    rd(8'h0C, v); chk("R3 R7 bit3", v, 16'h0008);
    chk("R7 pulse", {15'b0, host}, 16'h1);
    step(); chk("R7 pulse ends", {15'b0, host}, 16'h0);
    mod[0] = 1; step();
    chk("R6 level on", {15'b0, host}, 16'h1);
    wr(8'h0C, 16'h0008);
    rd(8'h0C, v); chk("R8 edge w1c", v, 16'h0001);
    mod[3] = 0; step();
    mod[3] = 1; step();
    chk("R7 dip", {15'b0, host}, 16'h0);
    step(); chk("R7 back high", {15'b0, host}, 16'h1);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    wr(8'h0C, 16'h0001);
    rd(8'h0C, v); chk("R8 w1c bit0", v, 16'h0008);
    chk("R8 host low", {15'b0, host}, 16'h0);
    wr(8'h08, 16'h0040);
    mod[6] = 1; step();
    wr(8'h0C, 16'h0040);
    rd(8'h0C, v); chk("R8 absent kept", v, 16'h0048);
    mod[6] = 0; step();
    rd(8'h0C, v); chk("R8 absent fall", v, 16'h0008);
  endtask

  task automatic t_ack();
    logic [15:0] v;
    wr(8'h06, 16'h0080);
    mod[5] = 1; step();
    rd(8'h0C, v); chk("R9 bit5 set", v, 16'h0028);
    ack = 1; ack_slot = 2; ack_off = 0; step();
    rd(8'h0C, v); chk("R9 wrong off", v, 16'h0028);
    ack_off = 2; step(); ack = 0;
    rd(8'h0C, v); chk("R9 level acked", v, 16'h0008);
    ack = 1; ack_slot = 1; ack_off = 2; step(); ack = 0;
    rd(8'h0C, v); chk("R9 edge kept", v, 16'h0008);
    wr(8'h0C, 16'h0008);
  endtask

  task automatic t_tmo();
    logic [15:0] v;
    tmo = 4'b0101; step(); tmo = 0;
    rd(8'h0C, v); chk("R10 set", v, 16'h5000);
    wr(8'h0C, 16'h1000);
    rd(8'h0C, v); chk("R10 clear", v, 16'h4000);
  endtask

  task automatic t_bad();
    logic [15:0] v;
    mod[0] = 0; step(); mod[0] = 1; step();
    we = 1; addr = 8'h0C; wdata = 16'h4101; step(); we = 0;
    chk("R11 flag", {15'b0, bad}, 16'h1);
    rd(8'h0C, v); chk("R11 no change", v, 16'h4001);
    step(); chk("R11 flag drops", {15'b0, bad}, 16'h0);
    wr(8'h0C, 16'h4001);
  endtask

  task automatic t_same();
    logic [15:0] v;
    mod[0] = 0; step();
    rd(8'h0C, v); chk("R12 pre", v, 16'h0);
    mod[0] = 1; we = 1; addr = 8'h0C; wdata = 16'h0001; step(); we = 0;
    rd(8'h0C, v); chk("R12 rise vs w1c", v, 16'h0001);
    mod[0] = 0; step();
    mod[0] = 1; ack = 1; ack_slot = 0; ack_off = 0; step(); ack = 0;
    rd(8'h0C, v); chk("R12 rise vs ack", v, 16'h0001);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    step();
    t_reset();
    t_map();
    t_disabled();
    t_level();
    t_edge();
    t_w1c();
    t_ack();
    t_tmo();
    t_bad();
    t_same();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule